// File: doc/BRIEF.md
# Per-Tile Variable-Rate Refresh Scheduler

This block drives refresh for a cache whose line array is built from dynamic memory cells. The array is cut into tiles of consecutive lines. Each tile holds a small period code. A shared base tick paces every tile. A tile is refreshed once every (code + 1) base ticks, so the periods are spaced linearly. A tile whose cells leak faster gets a short code, and a tile that holds charge well gets a long one. All lines of a tile share the one code, which is set by the weakest line in that tile.

When a tile runs out of time, it becomes pending. The scheduler serves pending tiles one at a time, lowest index first. For the chosen tile it walks every line in ascending order and raises one request per line. Each request waits for a grant from the array before the next line is presented. After retention profiling, software or a boot sequencer writes the period codes through a simple write port. Code 0 gives the conventional single-rate refresh. The base tick is meant to run at the worst-case uniform interval, on the order of 40 µs.

Top module: `tile_refresh_sched`

## Requirements
- R1: After reset there is no request, every tile code is 0 and every tile counter is 0, so each tile becomes pending on the first base tick.
- R2: A tile with code k starts a refresh sequence once every k+1 base ticks. Its counter is reloaded from the code when the sequence starts, so a tile waiting for service does not lengthen the next period.
- R3: A tile whose counter is 0 when a base tick arrives becomes pending. A pending tile stays pending until it is started or rewritten, so no expiry is lost.
- R4: When the sequencer is idle and one or more tiles are pending, the lowest-numbered pending tile starts in the next cycle. At most one tile starts per cycle.
- R5: A sequence issues exactly LINES_PER_TILE requests. The offsets run in ascending order from 0. ref_line carries the tile index in its upper bits and the line offset in its low log2(LINES_PER_TILE) bits. The request drops for at least one cycle after the last grant.
- R6: A request and its line stay unchanged until a cycle in which ref_gnt is high. ref_gnt while no request is raised has no effect.
- R7: A configuration write sets the tile's code and loads its counter with the new code. It also cancels that tile's pending refresh if the refresh has not started. A write in the same cycle the tile would have been started wins, and the tile is not started.
- R8: A configuration write never alters a sequence that is already running, including one for the tile being written.
- R9: A base tick in the same cycle a tile starts is not counted against that tile. Its counter holds exactly its code after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | One-cycle pulse per base refresh interval |
| cfg_we | input | 1 | Write strobe for a tile period code |
| cfg_tile | input | TILE_W | Tile index to write (must be below NUM_TILES) |
| cfg_code | input | CODE_W | New period code; period is code+1 base ticks |
| ref_req | output | 1 | Line refresh request to the array |
| ref_line | output | LINE_W | Line to refresh: {tile index, line offset} |
| ref_gnt | input | 1 | Array accepts the current request |

## Verification
A configuration write and a sequence start can hit the same tile in the same cycle. R7 makes the write win, and the tile is not started. The bench provokes this clash on purpose. In that phase it watches its own model for cycles where the sequencer is about to go idle-to-busy, and it writes the lowest pending tile in exactly that cycle. A base tick landing on the start cycle of a tile (R9) is provoked by ticking every cycle with short codes. In both cases the cycle-by-cycle model, written as plain integer arrays, must match the request and line on every clock. The number of sequences each tile received must also match the model.

// File: rtl/tile_refresh_pkg.sv
package tile_refresh_pkg;

  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_e;

  // number of base ticks between starts for a given period code
  function automatic int unsigned period_of(input int unsigned code);
    return code + 1;
  endfunction

endpackage

// File: rtl/trs_tile_ctr.sv
module trs_tile_ctr #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cfg_hit,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              start_hit,
  output logic              pending,
  output logic              expire
);

  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] cnt_q;

  assign expire = tick && !cfg_hit && !start_hit && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q  <= '0;
      cnt_q   <= '0;
      pending <= 1'b0;
    end else if (cfg_hit) begin
      code_q  <= cfg_code;
      cnt_q   <= cfg_code;
      pending <= 1'b0;
    end else if (start_hit) begin
      cnt_q   <= code_q;
      pending <= 1'b0;
    end else if (tick) begin
      if (cnt_q == '0) pending <= 1'b1;
      else             cnt_q   <= cnt_q - 1'b1;
    end
  end

  // R2 / R9: a start reloads the full code, even with a tick in that cycle
  p_reload_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_hit && !cfg_hit |=> cnt_q == $past(code_q));

  // R3: an expiry always leaves the tile pending
  p_expiry_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pending);

  // R3: pending is only dropped by a start or a write
  p_pending_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !start_hit && !cfg_hit |=> pending);

  // R7: a write loads the counter and cancels a waiting refresh
  p_cfg_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hit |=> !pending && cnt_q == $past(cfg_code) && code_q == $past(cfg_code));

endmodule

// File: rtl/trs_pick_lowest.sv
module trs_pick_lowest #(
  parameter int N  = 8,
  parameter int TW = 3
) (
  input  logic [N-1:0]  req_vec,
  output logic          any,
  output logic [TW-1:0] idx,
  output logic [N-1:0]  onehot
);

  function automatic logic [TW-1:0] lowest(input logic [N-1:0] v);
    logic [TW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = TW'(i);
    end
    return r;
  endfunction

  assign any    = |req_vec;
  assign idx    = lowest(req_vec);
  assign onehot = any ? (N'(1) << idx) : '0;

endmodule

// File: rtl/trs_line_seq.sv
module trs_line_seq
  import tile_refresh_pkg::*;
#(
  parameter int TW    = 3,
  parameter int OFF_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [TW-1:0]       start_tile,
  input  logic                gnt,
  output logic                busy,
  output logic [TW+OFF_W-1:0] line
);

  localparam logic [OFF_W-1:0] LAST = '1;

  seq_state_e       state_q;
  logic [TW-1:0]    tile_q;
  logic [OFF_W-1:0] off_q;
  logic             step;

  assign busy = (state_q == SEQ_RUN);
  assign line = {tile_q, off_q};
  assign step = busy && gnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      tile_q  <= '0;
      off_q   <= '0;
    end else if (start && !busy) begin
      state_q <= SEQ_RUN;
      tile_q  <= start_tile;
      off_q   <= '0;
    end else if (step) begin
      if (off_q == LAST) state_q <= SEQ_IDLE;
      else               off_q   <= off_q + 1'b1;
    end
  end

  // R6: request and line held until granted
  p_hold_until_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !gnt |=> busy && $stable(line));

  // R5: ascending offsets within a tile
  p_ascend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step && off_q != LAST |=> busy && off_q == $past(off_q) + 1'b1 && tile_q == $past(tile_q));

  // R5: request drops after the last line
  p_last_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step && off_q == LAST |=> !busy);

  // R5: every sequence begins at offset 0
  p_begin_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> off_q == '0);

endmodule

// File: rtl/tile_refresh_sched.sv
module tile_refresh_sched #(
  parameter int NUM_TILES      = 8,
  parameter int LINES_PER_TILE = 32,
  parameter int CODE_W         = 6,
  localparam int TILE_W = (NUM_TILES > 1) ? $clog2(NUM_TILES) : 1,
  localparam int OFF_W  = (LINES_PER_TILE > 1) ? $clog2(LINES_PER_TILE) : 1,
  localparam int LINE_W = TILE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_tick,
  input  logic              cfg_we,
  input  logic [TILE_W-1:0] cfg_tile,
  input  logic [CODE_W-1:0] cfg_code,
  output logic              ref_req,
  output logic [LINE_W-1:0] ref_line,
  input  logic              ref_gnt
);

  logic [NUM_TILES-1:0] cfg_hit;
  logic [NUM_TILES-1:0] pend;
  logic [NUM_TILES-1:0] expire;
  logic [NUM_TILES-1:0] eligible;
  logic [NUM_TILES-1:0] pick_vec;
  logic [NUM_TILES-1:0] start_vec;
  logic                 pick_any;
  logic [TILE_W-1:0]    pick_idx;
  logic                 seq_busy;
  logic                 start_go;

  // a write to a tile masks it from selection in that same cycle
  assign eligible  = pend & ~cfg_hit;
  assign start_go  = pick_any && !seq_busy;
  assign start_vec = start_go ? pick_vec : '0;

  for (genvar g = 0; g < NUM_TILES; g++) begin : g_tile
    assign cfg_hit[g] = cfg_we && (cfg_tile == TILE_W'(g));
    trs_tile_ctr #(.CODE_W(CODE_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (base_tick),
      .cfg_hit  (cfg_hit[g]),
      .cfg_code (cfg_code),
      .start_hit(start_vec[g]),
      .pending  (pend[g]),
      .expire   (expire[g])
    );
  end

  trs_pick_lowest #(.N(NUM_TILES), .TW(TILE_W)) u_pick (
    .req_vec(eligible),
    .any    (pick_any),
    .idx    (pick_idx),
    .onehot (pick_vec)
  );

  trs_line_seq #(.TW(TILE_W), .OFF_W(OFF_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_go),
    .start_tile(pick_idx),
    .gnt       (ref_gnt),
    .busy      (seq_busy),
    .line      (ref_line)
  );

  assign ref_req = seq_busy;

  // R4: never more than one tile started per cycle
  p_one_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_vec));

  // R4: a start makes the request rise with the chosen tile in the upper bits
  p_start_tile_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> ref_req && ref_line[LINE_W-1:OFF_W] == $past(pick_idx));

  // R7: a tile written this cycle is never the one started
  p_cfg_beats_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_vec & cfg_hit) == '0);

  // R8: a write does not disturb a waiting request
  p_cfg_no_disturb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req && !ref_gnt && cfg_we |=> ref_req && $stable(ref_line));

  // R1: no request in the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !ref_req);

endmodule

// File: tb/tile_refresh_sched_test.sv
module tile_refresh_sched_test;

  localparam int NT = 8;
  localparam int LP = 32;
  localparam int CW = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_tick = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_tile = '0;
  logic [5:0] cfg_code = '0;
  logic       ref_req;
  logic [7:0] ref_line;
  logic       ref_gnt = 1'b0;

  int n_checks = 0;
  int n_bad = 0;
  int cyc = 0;
  string tag = "R1";
  bit aim_clash = 1'b0;

  // behavioural reference state
  int m_code[NT];
  int m_cnt[NT];
  bit m_pend[NT];
  bit m_busy;
  int m_tile;
  int m_off;
  int m_starts[NT];
  int d_starts[NT];
  bit prev_req = 1'b0;
  int st;

  tile_refresh_sched #(.NUM_TILES(NT), .LINES_PER_TILE(LP), .CODE_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .cfg_we(cfg_we),
    .cfg_tile(cfg_tile), .cfg_code(cfg_code), .ref_req(ref_req),
    .ref_line(ref_line), .ref_gnt(ref_gnt)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NT; i++) begin
        m_code[i] = 0; m_cnt[i] = 0; m_pend[i] = 0;
      end
      m_busy = 0; m_tile = 0; m_off = 0;
    end else begin
      st = -1;
      if (!m_busy)
        for (int i = 0; i < NT; i++)
          if (st < 0 && m_pend[i] && !(cfg_we && cfg_tile == i)) st = i;
      for (int i = 0; i < NT; i++) begin
        if (cfg_we && cfg_tile == i) begin
          m_code[i] = cfg_code; m_cnt[i] = cfg_code; m_pend[i] = 0;
        end else if (st == i) begin
          m_cnt[i] = m_code[i]; m_pend[i] = 0;
        end else if (base_tick) begin
          if (m_cnt[i] == 0) m_pend[i] = 1;
          else m_cnt[i] = m_cnt[i] - 1;
        end
      end
      if (st >= 0) begin
        m_busy = 1; m_tile = st; m_off = 0; m_starts[st]++;
      end else if (m_busy && ref_gnt) begin
        if (m_off == LP - 1) m_busy = 0;
        else m_off = m_off + 1;
      end
    end
  end

  task automatic check(input string rq, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", rq, what, act, exp, cyc);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check(tag, int'(ref_req), int'(m_busy), "ref_req");
      if (m_busy) check(tag, int'(ref_line), m_tile * LP + m_off, "ref_line");
      if (ref_req && !prev_req) d_starts[ref_line[7:5]]++;
    end
    prev_req = ref_req;
  end

  always @(negedge clk) begin
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  task automatic write_code(input int t, input int c);
    @(negedge clk);
    cfg_we = 1; cfg_tile = 3'(t); cfg_code = 6'(c);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run(input string rq, input int ncyc, input int tick_every,
                     input int gnt_pct, input int cfg_pct, input int max_code);
    tag = rq;
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      base_tick = (k % tick_every) == 0;
      ref_gnt = ($urandom_range(99) < gnt_pct);
      cfg_we = 0;
      if (aim_clash && !m_busy) begin
        for (int i = NT - 1; i >= 0; i--)
          if (m_pend[i]) begin cfg_we = 1; cfg_tile = 3'(i); end
        cfg_code = 6'($urandom_range(max_code));
      end else if ($urandom_range(99) < cfg_pct) begin
        cfg_we = 1;
        cfg_tile = 3'($urandom_range(NT - 1));
        cfg_code = 6'($urandom_range(max_code));
      end
    end
    @(negedge clk);
    base_tick = 0; cfg_we = 0; ref_gnt = 0;
  endtask

  task automatic compare_starts(input string rq);
    for (int i = 0; i < NT; i++) check(rq, d_starts[i], m_starts[i], "sequence count per tile");
  endtask

  initial begin
    for (int i = 0; i < NT; i++) begin m_starts[i] = 0; d_starts[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: quiet after reset
    check("R1", int'(ref_req), 0, "ref_req after reset");
    // R1: code 0 everywhere, so one tick makes all tiles pending
    tag = "R1";
    @(negedge clk); base_tick = 1;
    @(negedge clk); base_tick = 0; ref_gnt = 1;
    repeat (NT * (LP + 1) + 4) @(negedge clk);
    for (int i = 0; i < NT; i++) check("R1", d_starts[i], 1, "one sequence per tile after first tick");
    ref_gnt = 0;

    // R2: distinct codes per tile, ticks far apart, full grants
    for (int i = 0; i < NT; i++) write_code(i, i);
    run("R2", 12000, 300, 100, 0, 0);
    repeat (NT * (LP + 2)) begin @(negedge clk); ref_gnt = 1; end
    ref_gnt = 0;
    compare_starts("R2");

    // R4 / R3: dense ticks, many tiles expiring together
    for (int i = 0; i < NT; i++) write_code(i, i % 3);
    run("R4", 8000, 7, 100, 0, 0);
    run("R3", 8000, 3, 60, 0, 0);
    compare_starts("R3");

    // R5 / R6: sparse grants, grants also while idle
    run("R5", 6000, 40, 100, 0, 0);
    run("R6", 10000, 25, 20, 0, 0);

    // R9: a tick in every cycle, so starts and ticks coincide
    for (int i = 0; i < NT; i++) write_code(i, i + 1);
    run("R9", 10000, 1, 80, 0, 0);

    // R8: random writes while sequences run
    run("R8", 10000, 9, 40, 30, 20);

    // R7: writes aimed at the tile about to be started
    aim_clash = 1;
    run("R7", 10000, 5, 70, 0, 4);
    aim_clash = 0;
    run("R7", 4000, 4, 70, 10, 4);
    repeat (NT * (LP + 2)) begin @(negedge clk); ref_gnt = 1; end
    ref_gnt = 0;
    compare_starts("R7");

    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule